// File: doc/BRIEF.md
# Multi-Clock Counter Comparison Monitor

This block watches several clock sources against one trusted reference clock. Each source reaches the block over two redundant output paths, and each path clocks its own free-running counter. The counters are Gray coded, carried into the reference domain through two-flop synchronizers and converted back to binary. A golden counter runs on the reference clock.

At the end of every comparison window, each path's count delta is checked against the golden delta. A path is bad when the two differ by more than a tolerance. If only one path of a source is bad, the fault lies in that output path and the I/O fail count goes up. If both paths are bad, the source itself failed and the source fail count goes up. Every error window sets a sticky flag, records an error class (stuck, frequency or transient), and takes a snapshot of the source's synchronized lock and status inputs. The host selects a source by index to read its state and clears flags with a write-one-to-clear mask.

Top module: `mcm_monitor`

## Requirements
- R1: After reset, every sticky flag is 0, every error class is 0 (none) and every fail count is 0.
- R2: A window is WIN reference cycles long. A path whose count delta over the window is within ±TOL of the golden delta raises no error.
- R3: When both paths of a source are bad in a window, that source's fail count rises by one and its sticky flag is set. Other sources' flags do not change.
- R4: When exactly one path of a source is bad in a window, that source's I/O fail count rises by one, its sticky flag is set, and its source fail count does not change.
- R5: Error class 1 (stuck) is recorded when a bad path's delta is zero. Later non-zero errors do not replace it until it is cleared.
- R6: Error class 2 (frequency) is recorded when a bad path's delta is non-zero and the class is not already stuck.
- R7: If a source had exactly one bad window and the window after it is good, the class becomes 3 (transient), provided the flag is still set.
- R8: On each error window, the source's lock and status inputs, sampled through a two-flop synchronizer, are stored as its snapshot.
- R9: Writing with clr_wr and a mask bit set clears that source's flag and class in the next cycle. Fail counts are kept. An error in the same cycle as a clear takes priority and leaves the flag set.
- R10: The read port returns the flag, class, snapshot and counts of the source chosen by rd_sel, combinationally. An index of N or above reads as zero.
- R11: Each fail count saturates at its all-ones value and never wraps.
- R12: The first window after reset only takes a baseline and never raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Trusted reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| mon_clk_a | input | N | First redundant path of each monitored source |
| mon_clk_b | input | N | Second redundant path of each monitored source |
| lock_in | input | N | Lock indication of each source (asynchronous) |
| stat_in | input | N | One status bit of each source (asynchronous) |
| clr_wr | input | 1 | Strobe for the clear mask |
| clr_mask | input | N | Write-one-to-clear mask for the sticky flags |
| rd_sel | input | SEL_W | Source index for the read port |
| err_flags | output | N | Sticky error flag of each source |
| rd_flag | output | 1 | Sticky flag of the selected source |
| rd_kind | output | 2 | Error class: 0 none, 1 stuck, 2 frequency, 3 transient |
| rd_lock | output | 1 | Lock snapshot from the last error |
| rd_stat | output | 1 | Status snapshot from the last error |
| rd_io_fails | output | FW | I/O (single path) fail count |
| rd_src_fails | output | FW | Source (both paths) fail count |

## Verification
A wrong Gray conversion or a wrong baseline register changes a path delta. That shows up as a false flag, or a missing one, at the first judged window end, at most two windows after the fault. A wrong saturation or increment shows on the read port at the window end that causes it. A bad run-length register shows only one window later, because the transient class is decided on the good window that follows the fault. The stimulus therefore places each disturbance mid-window and reads back after the recovery window.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_STUCK = 2'd1,
    KIND_FREQ  = 2'd2,
    KIND_TRANS = 2'd3
  } err_kind_e;

  // True when a path delta strays from the golden delta by more than tol.
  function automatic logic path_off(input int unsigned d, input int unsigned g,
                                    input int unsigned tol);
    int unsigned diff;
    diff = (d > g) ? (d - g) : (g - d);
    return diff > tol;
  endfunction

endpackage

// File: rtl/mcm_path_cnt.sv
module mcm_path_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] gray_o
);
  logic [CW-1:0] bin_q;
  logic [CW-1:0] bin_nx;

  assign bin_nx = bin_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/mcm_cdc_sync.sv
module mcm_cdc_sync #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] gray_i,
  output logic [CW-1:0] bin_o
);
  logic [CW-1:0] s1_q;
  logic [CW-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin_o[CW-1] = s2_q[CW-1];
    for (int i = CW - 2; i >= 0; i--) begin
      bin_o[i] = bin_o[i+1] ^ s2_q[i];
    end
  end
endmodule

// File: rtl/mcm_src_eval.sv
module mcm_src_eval
  import mcm_pkg::*;
#(
  parameter int CW  = 16,
  parameter int FW  = 8,
  parameter int TOL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_end,
  input  logic          primed,
  input  logic [CW-1:0] gold_delta,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  input  logic          lock_s,
  input  logic          stat_s,
  input  logic          clr,
  output logic          flag,
  output logic [1:0]    kind_o,
  output logic          lock_snap,
  output logic          stat_snap,
  output logic [FW-1:0] io_fails,
  output logic [FW-1:0] src_fails
);
  localparam logic [FW-1:0] FMAX = '1;

  logic [CW-1:0] prev_a, prev_b;
  logic [CW-1:0] delta_a, delta_b;
  logic          judge, bad_a, bad_b, err, err_both, err_single, stuck_hit, trans_hit;
  logic [1:0]    run_q;
  err_kind_e     kind_q;

  assign delta_a    = cnt_a - prev_a;
  assign delta_b    = cnt_b - prev_b;
  assign judge      = win_end && primed;
  assign bad_a      = judge && path_off(32'(delta_a), 32'(gold_delta), TOL);
  assign bad_b      = judge && path_off(32'(delta_b), 32'(gold_delta), TOL);
  assign err        = bad_a || bad_b;
  assign err_both   = bad_a && bad_b;
  assign err_single = bad_a ^ bad_b;
  assign stuck_hit  = (bad_a && (delta_a == '0)) || (bad_b && (delta_b == '0));
  assign trans_hit  = judge && !err && (run_q == 2'd1) && flag && !clr;
  assign kind_o     = kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a    <= '0;
      prev_b    <= '0;
      run_q     <= '0;
      flag      <= 1'b0;
      kind_q    <= KIND_NONE;
      lock_snap <= 1'b0;
      stat_snap <= 1'b0;
      io_fails  <= '0;
      src_fails <= '0;
    end else begin
      if (win_end) begin
        prev_a <= cnt_a;
        prev_b <= cnt_b;
      end
      if (err) begin
        if (run_q != 2'd3) run_q <= run_q + 2'd1;
      end else if (win_end) begin
        run_q <= '0;
      end
      if (err) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (err) begin
        if (stuck_hit) kind_q <= KIND_STUCK;
        else if (kind_q != KIND_STUCK) kind_q <= KIND_FREQ;
      end else if (trans_hit) begin
        kind_q <= KIND_TRANS;
      end else if (clr) begin
        kind_q <= KIND_NONE;
      end
      if (err) begin
        lock_snap <= lock_s;
        stat_snap <= stat_s;
      end
      if (err_both && src_fails != FMAX) src_fails <= src_fails + 1'b1;
      if (err_single && io_fails != FMAX) io_fails <= io_fails + 1'b1;
    end
  end

  a_r3_src_count: assert property (@(posedge clk) disable iff (!rst_n)
    (err_both && src_fails != FMAX) |=> src_fails == $past(src_fails) + 1'b1);
  a_r4_io_count: assert property (@(posedge clk) disable iff (!rst_n)
    (err_single && io_fails != FMAX) |=> io_fails == $past(io_fails) + 1'b1);
  a_r4_single_keeps_src: assert property (@(posedge clk) disable iff (!rst_n)
    err_single |=> $stable(src_fails));
  a_r11_src_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (src_fails == FMAX) |=> src_fails == FMAX);
  a_r11_io_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (io_fails == FMAX) |=> io_fails == FMAX);
  a_r9_error_wins: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> flag);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !err) |=> !flag);
  a_r9_kind_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flag == (kind_q != KIND_NONE));
  a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (lock_snap == $past(lock_s)) && (stat_snap == $past(stat_s)));
  a_r5_stuck_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == KIND_STUCK && !clr) |=> kind_q == KIND_STUCK);
endmodule

// File: rtl/mcm_monitor.sv
module mcm_monitor #(
  parameter int N   = 6,
  parameter int CW  = 16,
  parameter int FW  = 8,
  parameter int WIN = 1024,
  parameter int TOL = 2,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [N-1:0]     mon_clk_a,
  input  logic [N-1:0]     mon_clk_b,
  input  logic [N-1:0]     lock_in,
  input  logic [N-1:0]     stat_in,
  input  logic             clr_wr,
  input  logic [N-1:0]     clr_mask,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [N-1:0]     err_flags,
  output logic             rd_flag,
  output logic [1:0]       rd_kind,
  output logic             rd_lock,
  output logic             rd_stat,
  output logic [FW-1:0]    rd_io_fails,
  output logic [FW-1:0]    rd_src_fails
);
  localparam int WCW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WCW-1:0] WLAST = WCW'(WIN - 1);

  logic [WCW-1:0] win_cnt;
  logic           win_end, primed;
  logic [CW-1:0]  gold_cnt, gold_prev, gold_delta;
  logic [N-1:0]   lock_s1, lock_s2, stat_s1, stat_s2;

  logic [CW-1:0]  cnt_a [N];
  logic [CW-1:0]  cnt_b [N];
  logic [1:0]     kind_v [N];
  logic [N-1:0]   lock_v, stat_v;
  logic [FW-1:0]  io_v  [N];
  logic [FW-1:0]  src_v [N];

  assign win_end    = (win_cnt == WLAST);
  assign gold_delta = gold_cnt - gold_prev;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt   <= '0;
      primed    <= 1'b0;
      gold_cnt  <= '0;
      gold_prev <= '0;
      lock_s1   <= '0;
      lock_s2   <= '0;
      stat_s1   <= '0;
      stat_s2   <= '0;
    end else begin
      win_cnt  <= win_end ? '0 : win_cnt + 1'b1;
      gold_cnt <= gold_cnt + 1'b1;
      if (win_end) begin
        gold_prev <= gold_cnt;
        primed    <= 1'b1;
      end
      lock_s1 <= lock_in;
      lock_s2 <= lock_s1;
      stat_s1 <= stat_in;
      stat_s2 <= stat_s1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    logic [CW-1:0] gray_a, gray_b;

    mcm_path_cnt #(.CW(CW)) u_cnt_a (.clk(mon_clk_a[g]), .rst_n(rst_n), .gray_o(gray_a));
    mcm_path_cnt #(.CW(CW)) u_cnt_b (.clk(mon_clk_b[g]), .rst_n(rst_n), .gray_o(gray_b));
    mcm_cdc_sync #(.CW(CW)) u_sync_a (.clk(ref_clk), .rst_n(rst_n), .gray_i(gray_a), .bin_o(cnt_a[g]));
    mcm_cdc_sync #(.CW(CW)) u_sync_b (.clk(ref_clk), .rst_n(rst_n), .gray_i(gray_b), .bin_o(cnt_b[g]));

    mcm_src_eval #(.CW(CW), .FW(FW), .TOL(TOL)) u_eval (
      .clk       (ref_clk),
      .rst_n     (rst_n),
      .win_end   (win_end),
      .primed    (primed),
      .gold_delta(gold_delta),
      .cnt_a     (cnt_a[g]),
      .cnt_b     (cnt_b[g]),
      .lock_s    (lock_s2[g]),
      .stat_s    (stat_s2[g]),
      .clr       (clr_wr && clr_mask[g]),
      .flag      (err_flags[g]),
      .kind_o    (kind_v[g]),
      .lock_snap (lock_v[g]),
      .stat_snap (stat_v[g]),
      .io_fails  (io_v[g]),
      .src_fails (src_v[g])
    );
  end

  always_comb begin
    rd_flag      = 1'b0;
    rd_kind      = '0;
    rd_lock      = 1'b0;
    rd_stat      = 1'b0;
    rd_io_fails  = '0;
    rd_src_fails = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(rd_sel) == i) begin
        rd_flag      = err_flags[i];
        rd_kind      = kind_v[i];
        rd_lock      = lock_v[i];
        rd_stat      = stat_v[i];
        rd_io_fails  = io_v[i];
        rd_src_fails = src_v[i];
      end
    end
  end

  a_r2_golden_window: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_end && primed) |-> gold_delta == CW'(WIN));
  a_r12_no_flag_before_prime: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !primed |=> err_flags == '0);
endmodule

// File: tb/mcm_monitor_bench.sv
module mcm_monitor_bench;
  localparam int N = 6, CW = 16, FW = 3, WIN = 64, TOL = 2;
  localparam int SEL_W = $clog2(N);
  localparam int REF_HALF = 10000;
  localparam logic [FW-1:0] FMAX = '1;
  // fields: source, period A (ns), period B (ns), expected class, path kind (0 none, 1 both, 2 one)
  localparam int NVEC = 4;
  localparam int VEC [NVEC][5] = '{
    '{0, 20, 20, 0, 0},
    '{1, 19, 19, 2, 1},
    '{3, 21, 20, 2, 2},
    '{5, 20, 22, 2, 2}
  };

  logic             ref_clk = 1'b0;
  logic             rst_n;
  logic [2*N-1:0]   mclk;
  logic [N-1:0]     lock_in, stat_in, clr_mask, err_flags;
  logic             clr_wr;
  logic [SEL_W-1:0] rd_sel;
  logic             rd_flag, rd_lock, rd_stat;
  logic [1:0]       rd_kind;
  logic [FW-1:0]    rd_io_fails, rd_src_fails;

  int  half [2*N];
  bit  hold [2*N];
  int  cyc;
  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;

  mcm_monitor #(.N(N), .CW(CW), .FW(FW), .WIN(WIN), .TOL(TOL)) u_mcm_monitor (
    .ref_clk(ref_clk), .rst_n(rst_n),
    .mon_clk_a(mclk[N-1:0]), .mon_clk_b(mclk[2*N-1:N]),
    .lock_in(lock_in), .stat_in(stat_in),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .rd_sel(rd_sel),
    .err_flags(err_flags), .rd_flag(rd_flag), .rd_kind(rd_kind),
    .rd_lock(rd_lock), .rd_stat(rd_stat),
    .rd_io_fails(rd_io_fails), .rd_src_fails(rd_src_fails)
  );

  always #(REF_HALF) ref_clk = ~ref_clk;

  for (genvar g = 0; g < 2 * N; g++) begin : g_mclk
    initial begin
      mclk[g] = 1'b0;
      #(137 * (g + 1));
      forever begin
        if (hold[g]) #1000;
        else begin
          #(half[g]);
          mclk[g] = ~mclk[g];
        end
      end
    end
  end

  always @(posedge ref_clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rd(input int s);
    rd_sel = SEL_W'(s);
    #1;
  endtask

  task automatic wait_ends(input int n);
    repeat (n) begin
      @(negedge ref_clk);
      while (cyc % WIN != 0) @(negedge ref_clk);
    end
  endtask

  task automatic to_mid();
    @(negedge ref_clk);
    while (cyc % WIN != WIN / 2) @(negedge ref_clk);
  endtask

  task automatic clear(input int s);
    @(negedge ref_clk);
    clr_mask = N'(1) << s;
    clr_wr   = 1'b1;
    @(negedge ref_clk);
    clr_wr   = 1'b0;
    clr_mask = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge ref_clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int io0, src0, s;
    for (int i = 0; i < 2 * N; i++) begin
      half[i] = REF_HALF;
      hold[i] = 1'b0;
    end
    rst_n = 1'b0; clr_wr = 1'b0; clr_mask = '0; rd_sel = '0;
    lock_in = '1; stat_in = '0;
    lock_in[2] = 1'b0; stat_in[2] = 1'b1;
    repeat (5) @(negedge ref_clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0);
    chk(err_flags == '0, "R1", "flags after reset", int'(err_flags), 0);
    chk(rd_kind == 2'd0, "R1", "class after reset", int'(rd_kind), 0);
    chk(rd_io_fails == '0 && rd_src_fails == '0, "R1", "counts after reset",
        int'(rd_io_fails) + int'(rd_src_fails), 0);

    // R12 baseline window, R2 nominal clocks
    wait_ends(1);
    chk(err_flags == '0, "R12", "flags after first window", int'(err_flags), 0);
    wait_ends(2);
    chk(err_flags == '0, "R2", "flags with nominal clocks", int'(err_flags), 0);

    // table walk: R2, R3, R4, R6, R10
    for (int v = 0; v < NVEC; v++) begin
      s = VEC[v][0];
      rd(s);
      io0 = int'(rd_io_fails); src0 = int'(rd_src_fails);
      half[s]     = VEC[v][1] * 500;
      half[s + N] = VEC[v][2] * 500;
      wait_ends(4);
      half[s] = REF_HALF; half[s + N] = REF_HALF;
      wait_ends(2);
      chk(err_flags == ((VEC[v][3] != 0) ? (N'(1) << s) : N'(0)), "R10", "flag vector",
          int'(err_flags), (VEC[v][3] != 0) ? (1 << s) : 0);
      rd(s);
      chk(int'(rd_kind) == VEC[v][3], "R6", "class", int'(rd_kind), VEC[v][3]);
      if (VEC[v][4] == 1) begin
        chk(int'(rd_src_fails) > src0 && int'(rd_io_fails) == io0, "R3", "source count rises",
            int'(rd_src_fails), src0 + 1);
      end else if (VEC[v][4] == 2) begin
        chk(int'(rd_io_fails) > io0 && int'(rd_src_fails) == src0, "R4", "io count rises",
            int'(rd_io_fails), io0 + 1);
      end else begin
        chk(int'(rd_io_fails) == io0 && int'(rd_src_fails) == src0, "R2", "counts steady",
            int'(rd_io_fails) + int'(rd_src_fails), io0 + src0);
      end
      clear(s);
      rd(s);
      chk(rd_flag == 1'b0 && rd_kind == 2'd0, "R9", "flag cleared", int'(rd_flag), 0);
    end

    // R7 transient on path A of source 2, R8 snapshot
    to_mid();
    hold[2] = 1'b1;
    repeat (8) @(negedge ref_clk);
    hold[2] = 1'b0;
    wait_ends(2);
    rd(2);
    chk(rd_flag == 1'b1, "R7", "transient flag", int'(rd_flag), 1);
    chk(rd_kind == 2'd3, "R7", "transient class", int'(rd_kind), 3);
    chk(rd_io_fails == FW'(1) && rd_src_fails == '0, "R4", "transient io count",
        int'(rd_io_fails), 1);
    chk(rd_lock == 1'b0 && rd_stat == 1'b1, "R8", "snapshot lock/stat",
        int'({rd_lock, rd_stat}), 1);
    clear(2);

    // R5 stuck source 4 (both paths), R11 saturation
    to_mid();
    hold[4] = 1'b1; hold[4 + N] = 1'b1;
    repeat (9 * WIN) @(negedge ref_clk);
    hold[4] = 1'b0; hold[4 + N] = 1'b0;
    wait_ends(3);
    rd(4);
    chk(rd_kind == 2'd1, "R5", "stuck class", int'(rd_kind), 1);
    chk(rd_src_fails == FMAX, "R11", "source count saturated", int'(rd_src_fails), int'(FMAX));
    chk(rd_io_fails == '0, "R3", "io count untouched", int'(rd_io_fails), 0);
    chk(rd_lock == 1'b1 && rd_stat == 1'b0, "R8", "stuck snapshot", int'({rd_lock, rd_stat}), 2);
    chk(err_flags == N'(1 << 4), "R3", "only source 4 flagged", int'(err_flags), 1 << 4);
    clear(4);
    wait_ends(1);
    rd(4);
    chk(rd_flag == 1'b0 && rd_kind == 2'd0, "R9", "stuck cleared", int'(rd_kind), 0);
    chk(rd_src_fails == FMAX, "R9", "count kept after clear", int'(rd_src_fails), int'(FMAX));

    // R10 out-of-range index reads zero
    rd(7);
    chk(rd_src_fails == '0 && rd_flag == 1'b0, "R10", "out-of-range read",
        int'(rd_src_fails), 0);

    finish_run();
  end
endmodule